// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block computes a fixed four-tap finite impulse response over unsigned 8-bit samples without a single multiplier. A small table holds the sum of every subset of the four coefficients. Once a sample is accepted, the block walks the bit positions of the four stored samples from least to most significant. In each bit cycle it gathers one bit from every sample into a 4-bit index, reads the matching partial sum and adds it to a running total. That total then shifts right by one place, and the bit that falls out goes into a register that collects the low half of the result.

The producer offers a sample with a one-cycle strobe. The sample is taken only while the engine is idle and is dropped otherwise. Nine cycles after acceptance, an 18-bit result appears with a one-cycle valid pulse. The result stays on the output until the next result replaces it. The coefficients are unsigned elaboration-time constants, and their total must stay at or below 1023.

Top module: `bitserial_fir`

## Requirements
- R1: When y_valid is high, y_data equals c0*x0 + c1*x1 + c2*x2 + c3*x3. Here x0 is the sample accepted last and x1, x2, x3 are the three accepted before it, oldest last. The default coefficients are c0=255, c1=300, c2=200 and c3=268, packed with c0 in the lowest 10 bits of COEFS.
- R2: Only accepted samples enter the delay line. Each acceptance moves every stored sample one place older, and the oldest one is discarded.
- R3: A sample is accepted on a rising edge where smp_valid is high and the block is idle. y_valid is then high during exactly one cycle, the ninth cycle after that edge, which is the cycle after the eighth bit step.
- R4: A sample offered while the block is busy is ignored. It affects neither the delay line nor any later result.
- R5: While rst_n is low, and right after reset, y_valid and y_data are 0 and all four stored samples are 0.
- R6: y_data changes only in a cycle where y_valid is high. Between results it holds its last value.
- R7: Full-scale inputs (all four samples 0xFF) give 1023*255 = 260865 without overflow of the 18-bit result.
- R8: The block is idle again in the cycle where y_valid is high. A sample held continuously valid is therefore accepted once every 9 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Sample offered this cycle |
| smp_data | input | 8 | Unsigned sample value |
| y_valid | output | 1 | One-cycle strobe: y_data holds a new result |
| y_data | output | 18 | Filter result, held between strobes |

## Verification
The bench uses four kinds of input. A unit impulse followed by zeros brings each coefficient out alone, in order. This separates an error in the tap ordering from an error in the table contents. Four full-scale samples load every index bit in every bit step, which reveals a truncated carry or a short accumulator. A valid strobe held high for many cycles shows whether samples offered while busy leak into the delay line, and whether acceptance resumes in the cycle of the result pulse. Random samples with a random strobe density then mix all bit patterns and gap lengths against a behavioural model of the filter sum.

// File: rtl/bsfir_pkg.sv
package bsfir_pkg;

    localparam int unsigned BSF_TAPS     = 4;
    localparam int unsigned BSF_SAMPLE_W = 8;
    localparam int unsigned BSF_COEF_W   = 10;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BITS = 1'b1
    } bsf_phase_e;

endpackage

// File: rtl/bsfir_delay_line.sv
module bsfir_delay_line #(
    parameter int unsigned TAPS = 4,
    parameter int unsigned W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      shift_en,
    input  logic [W-1:0]              din,
    output logic [TAPS-1:0][W-1:0]    taps
);

    logic [TAPS-1:0][W-1:0] taps_d;
    logic [TAPS-1:0][W-1:0] taps_q;

    // Stage 0 takes the new sample; every other stage takes its younger neighbour.
    always_comb begin
        taps_d = taps_q;
        if (shift_en) begin
            taps_d[0] = din;
        end
    end

    for (genvar i = 1; i < TAPS; i++) begin : g_stage
        logic [W-1:0] stage_d;
        always_comb begin
            stage_d = shift_en ? taps_q[i-1] : taps_q[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) taps_q[i] <= '0;
            else        taps_q[i] <= stage_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps_q[0] <= '0;
        else        taps_q[0] <= taps_d[0];
    end

    assign taps = taps_q;

endmodule

// File: rtl/bsfir_bit_slice.sv
module bsfir_bit_slice #(
    parameter int unsigned TAPS  = 4,
    parameter int unsigned W     = 8,
    parameter int unsigned SEL_W = 3
) (
    input  logic [TAPS-1:0][W-1:0] taps,
    input  logic [SEL_W-1:0]       bit_sel,
    output logic [TAPS-1:0]        index
);

    // Index bit i comes from the sample in delay stage i.
    for (genvar i = 0; i < TAPS; i++) begin : g_pick
        assign index[i] = taps[i][bit_sel];
    end

endmodule

// File: rtl/bsfir_coef_rom.sv
module bsfir_coef_rom #(
    parameter int unsigned          TAPS   = 4,
    parameter int unsigned          COEF_W = 10,
    parameter logic [TAPS*COEF_W-1:0] COEFS = '0
) (
    input  logic [TAPS-1:0]    index,
    output logic [COEF_W-1:0]  psum
);

    localparam int unsigned ENTRIES = 1 << TAPS;

    function automatic logic [COEF_W-1:0] subset_sum(input int unsigned k);
        logic [COEF_W-1:0] s;
        s = '0;
        for (int unsigned i = 0; i < TAPS; i++) begin
            if (((k >> i) & 1) != 0) begin
                s = s + COEFS[i*COEF_W +: COEF_W];
            end
        end
        return s;
    endfunction

    logic [ENTRIES-1:0][COEF_W-1:0] table_w;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        assign table_w[k] = subset_sum(k);
    end

    assign psum = table_w[index];

endmodule

// File: rtl/bitserial_fir.sv
module bitserial_fir #(
    parameter int unsigned TAPS     = bsfir_pkg::BSF_TAPS,
    parameter int unsigned SAMPLE_W = bsfir_pkg::BSF_SAMPLE_W,
    parameter int unsigned COEF_W   = bsfir_pkg::BSF_COEF_W,
    parameter logic [TAPS*COEF_W-1:0] COEFS =
        {10'd268, 10'd200, 10'd300, 10'd255},
    parameter int unsigned Y_W      = SAMPLE_W + COEF_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    output logic                y_valid,
    output logic [Y_W-1:0]      y_data
);
    import bsfir_pkg::*;

    localparam int unsigned SUM_W = COEF_W + 1;
    localparam int unsigned CNT_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

    typedef struct packed {
        bsf_phase_e          phase;
        logic [CNT_W-1:0]    cnt;
        logic [COEF_W-1:0]   acc;
        logic [SAMPLE_W-1:0] low;
        logic                y_valid;
        logic [Y_W-1:0]      y;
    } state_t;

    state_t st_d, st_q;

    logic                          accept_w;
    logic                          busy_w;
    logic [TAPS-1:0][SAMPLE_W-1:0] taps_w;
    logic [TAPS-1:0]               index_w;
    logic [COEF_W-1:0]             psum_w;
    logic [SUM_W-1:0]              sum_w;

    assign busy_w   = (st_q.phase == PH_BITS);
    assign accept_w = smp_valid && !busy_w;

    bsfir_delay_line #(
        .TAPS (TAPS),
        .W    (SAMPLE_W)
    ) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept_w),
        .din      (smp_data),
        .taps     (taps_w)
    );

    bsfir_bit_slice #(
        .TAPS  (TAPS),
        .W     (SAMPLE_W),
        .SEL_W (CNT_W)
    ) u_slice (
        .taps    (taps_w),
        .bit_sel (st_q.cnt),
        .index   (index_w)
    );

    bsfir_coef_rom #(
        .TAPS   (TAPS),
        .COEF_W (COEF_W),
        .COEFS  (COEFS)
    ) u_rom (
        .index (index_w),
        .psum  (psum_w)
    );

    // Adder: running total plus the partial sum for this bit position.
    assign sum_w = {1'b0, st_q.acc} + {1'b0, psum_w};

    always_comb begin
        st_d         = st_q;
        st_d.y_valid = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (smp_valid) begin
                    st_d.phase = PH_BITS;
                    st_d.cnt   = '0;
                    st_d.acc   = '0;
                    st_d.low   = '0;
                end
            end
            PH_BITS: begin
                st_d.acc = sum_w[SUM_W-1:1];
                st_d.low = {sum_w[0], st_q.low[SAMPLE_W-1:1]};
                if (st_q.cnt == LAST_BIT) begin
                    st_d.phase   = PH_IDLE;
                    st_d.y_valid = 1'b1;
                    st_d.y       = {sum_w[SUM_W-1:1], sum_w[0], st_q.low[SAMPLE_W-1:1]};
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_IDLE;
            st_q.cnt     <= '0;
            st_q.acc     <= '0;
            st_q.low     <= '0;
            st_q.y_valid <= 1'b0;
            st_q.y       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_valid = st_q.y_valid;
    assign y_data  = st_q.y;

endmodule

// File: rtl/bsfir_chk.sv
module bsfir_chk #(
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned Y_W      = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                smp_valid,
    input logic                busy,
    input logic                y_valid,
    input logic [Y_W-1:0]      y_data,
    input logic [SAMPLE_W-1:0] tap0,
    input logic [SAMPLE_W-1:0] tap1
);

    logic       accept;
    logic [7:0] since_q;

    assign accept = smp_valid && !busy;

    // Cycles elapsed since the last acceptance, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_q <= '0;
        else if (accept)            since_q <= 8'd1;
        else if (since_q != '0 && since_q != 8'hFF) since_q <= since_q + 8'd1;
    end

    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |=> !y_valid);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (since_q == 8'(SAMPLE_W + 1)));

    a_r4_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && smp_valid) |=> $stable(tap0));

    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (tap1 == $past(tap0)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !y_valid |=> (y_valid || $stable(y_data)));

    a_r8_idle_at_result: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> !busy);

endmodule

bind bitserial_fir bsfir_chk #(
    .SAMPLE_W (SAMPLE_W),
    .Y_W      (Y_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .busy      (busy_w),
    .y_valid   (y_valid),
    .y_data    (y_data),
    .tap0      (taps_w[0]),
    .tap1      (taps_w[1])
);

// File: tb/sim_bitserial_fir.sv
module sim_bitserial_fir;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [7:0]  smp_data = '0;
    logic        y_valid;
    logic [17:0] y_data;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    int coef [4] = '{255, 300, 200, 268};
    int hist [4] = '{0, 0, 0, 0};
    int rem = 0;
    int pend = 0;
    bit exp_valid = 0;
    int exp_y = 0;
    string tag = "R5";

    always #10 clk = ~clk;

    bitserial_fir u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .y_valid   (y_valid),
        .y_data    (y_data)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    // One clock: compare outputs at the falling edge, then drive the next input
    // and advance the behavioural model by one rising edge.
    task automatic step(input bit v, input int d);
        @(negedge clk);
        check({tag, "/R3 valid"}, int'(y_valid), int'(exp_valid));
        check({tag, "/R1 R6 data"}, int'(y_data), exp_y);
        smp_valid = v;
        smp_data  = 8'(d);
        exp_valid = 0;
        if (rst_n) begin
            if (rem == 0) begin
                if (v) begin
                    for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
                    hist[0] = d;
                    pend = 0;
                    for (int i = 0; i < 4; i++) pend += coef[i] * hist[i];
                    rem = 8;
                end
            end else begin
                rem--;
                if (rem == 0) begin
                    exp_valid = 1;
                    exp_y = pend;
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 100000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        tag = "R5";
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R1 R2: impulse then zeros brings out c0, c1, c2, c3 in turn
        tag = "R1";
        step(1, 1); idle(9);
        for (int k = 0; k < 4; k++) begin
            step(1, 0); idle(9);
        end

        // R7: full scale
        tag = "R7";
        for (int k = 0; k < 4; k++) begin
            step(1, 255); idle(9);
        end
        idle(5);

        // R4 R8: strobe held high, samples changing every cycle
        tag = "R4";
        for (int k = 0; k < 120; k++) step(1, (k * 37 + 11) & 255);
        idle(12);

        // R6: long quiet gap, output must hold
        tag = "R6";
        idle(30);

        // R1: random stream with random strobe density
        tag = "R1";
        for (int k = 0; k < 4000; k++) begin
            step(($urandom % 4) != 0, $urandom % 256);
        end
        idle(12);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule